// File: doc/BRIEF.md
# Comparator On-Time Capture and Cycle Accumulator

This block is the digital half of an integrating voltage-to-time converter. It drives the fixed-rate force-switching phase that makes the analog integrator ramp, samples the asynchronous comparator that follows the integrator, and counts the clocks during which the comparator is high in every force period. With zero input the comparator duty is one half. The duty grows or shrinks with the measured voltage, so each period's high-time count is a sample of that voltage.

A start strobe arms a conversion cycle. The cycle begins at the next period boundary, so a partial period is never summed. It then adds the per-period counts of a fixed number of whole periods into one total. At the default settings this is 60 periods of about 3.333 ms each at a 16 MHz count clock, giving 200 ms. A period in which the comparator never changes level means the integrator has hit a rail. Such a period contributes a fixed minimum count when the comparator is low and a fixed maximum when it is high, and the cycle is then flagged as overrange. Offset removal, slope scaling and all later arithmetic belong to the consumer of the total.

Top module: `pwm_ontime_accum`

## Requirements
- R1: While reset is applied, and until the first period boundary after it, total is 0, done is 0, overrange is 0 and force_phase is 1.
- R2: A force period lasts CLK_PER_PERIOD clocks, plus one extra clock in each period that follows a boundary at which a fractional accumulator (adding FRAC_NUM, wrapping at FRAC_DEN, starting at 0) wraps. force_phase is 1 for the first CLK_PER_PERIOD/2 clocks of each period and 0 for the rest.
- R3: comp_in passes through two synchronizing flops. A period's count is the number of its clocks in which the synchronized level is 1, and it restarts at every period boundary.
- R4: If the synchronized comparator shows no level change during a whole period, that period contributes MAX_COUNT when the level at the boundary is 1 and MIN_COUNT when it is 0.
- R5: After start, accumulation begins at the first period boundary that falls after the strobe. The period ending at that boundary is discarded, so a partial period is never summed.
- R6: Exactly PERIODS whole periods are summed. Total takes the sum, and done is 1 for exactly one clock, in the cycle right after the boundary that closes the last period.
- R7: overrange is updated together with total at each completion. It is 1 when any period of that cycle used a substituted count, and 0 otherwise.
- R8: A start strobe while a cycle is summing is ignored. It neither restarts the cycle nor queues another one.
- R9: total and overrange hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| comp_in | input | 1 | Asynchronous comparator output |
| start | input | 1 | One-clock strobe that arms a conversion cycle |
| force_phase | output | 1 | Force-switching phase: 1 in the first half of each period |
| total | output | TOTAL_W | Sum of the per-period counts of the last completed cycle |
| done | output | 1 | One-clock pulse when total is updated |
| overrange | output | 1 | Last completed cycle used a substituted count |

## Verification
A comparator level change reaches the count two clocks later, through the synchronizer. A period's count is fixed in the clock that closes the period. Total, overrange and done change at the following edge, so they are due one clock after the closing boundary, and force_phase changes in the clock after each boundary. The bench holds a behavioural model that steps once per rising edge and compares every output at the falling edge, so each result is checked in exactly the cycle it is due. Targeted checks on rail-stuck comparator levels and on the start-to-done latency add fixed expected values on top of that comparison.

// File: rtl/ota_pkg.sv
package ota_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_ARMED = 2'd1,
    ACC_RUN   = 2'd2
  } acc_state_e;
endpackage

// File: rtl/ota_rst_sync.sv
module ota_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ota_period_gen.sv
module ota_period_gen #(
  parameter int CLK_PER_PERIOD = 53333,
  parameter int FRAC_NUM       = 1,
  parameter int FRAC_DEN       = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic force_phase
);
  localparam int PW   = $clog2(CLK_PER_PERIOD + 1);
  localparam int FW   = $clog2(FRAC_NUM + FRAC_DEN + 1);
  localparam int HALF = CLK_PER_PERIOD / 2;

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [FW-1:0] facc_q, facc_d;
  logic          long_q, long_d;
  logic [PW-1:0] last_pos;
  logic [FW-1:0] facc_sum;

  assign last_pos    = PW'(CLK_PER_PERIOD - 1) + PW'(long_q);
  assign tick        = (pcnt_q == last_pos);
  assign force_phase = (pcnt_q < PW'(HALF));
  assign facc_sum    = facc_q + FW'(FRAC_NUM);

  always_comb begin
    pcnt_d = pcnt_q + PW'(1);
    facc_d = facc_q;
    long_d = long_q;
    if (tick) begin
      pcnt_d = '0;
      if (facc_sum >= FW'(FRAC_DEN)) begin
        facc_d = facc_sum - FW'(FRAC_DEN);
        long_d = 1'b1;
      end else begin
        facc_d = facc_sum;
        long_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      facc_q <= '0;
      long_q <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      facc_q <= facc_d;
      long_q <= long_d;
    end
  end

  // R2
  pcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PW'(CLK_PER_PERIOD));

  // R2
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> force_phase);
endmodule

// File: rtl/ota_ontime_meas.sv
module ota_ontime_meas #(
  parameter int CLK_PER_PERIOD = 53333,
  parameter int MIN_COUNT      = 8000,
  parameter int MAX_COUNT      = 44800,
  parameter int SYNC_STAGES    = 2,
  parameter int CW             = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          comp_async,
  input  logic          tick,
  output logic [CW-1:0] period_val,
  output logic          period_subst
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level, change;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   seen_q, seen_d;
  logic                   hit;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= comp_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign level  = sync_q[SYNC_STAGES-1];
  assign change = level ^ prev_q;
  assign hit    = seen_q | change;

  always_comb begin
    period_subst = !hit;
    if (hit)        period_val = cnt_q + CW'(level);
    else if (level) period_val = CW'(MAX_COUNT);
    else            period_val = CW'(MIN_COUNT);
  end

  always_comb begin
    if (tick) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else begin
      cnt_d  = cnt_q + CW'(level);
      seen_d = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= level;
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  // R3
  ontime_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CLK_PER_PERIOD));

  // R4
  subst_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period_subst) |-> $stable(level));
endmodule

// File: rtl/ota_cycle_accum.sv
module ota_cycle_accum
  import ota_pkg::*;
#(
  parameter int PERIODS = 60,
  parameter int CW      = 16,
  parameter int TW      = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic [CW-1:0] period_val,
  input  logic          period_subst,
  output logic [TW-1:0] total,
  output logic          done,
  output logic          overrange
);
  localparam int IW = (PERIODS > 1) ? $clog2(PERIODS) : 1;

  acc_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [TW-1:0] sum_q, sum_d, res_q, res_d;
  logic          ovr_q, ovr_d, ovo_q, ovo_d, done_q, done_d;
  logic [TW-1:0] sum_next;
  logic          ovr_next;

  assign sum_next = sum_q + TW'(period_val);
  assign ovr_next = ovr_q | period_subst;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    sum_d  = sum_q;
    ovr_d  = ovr_q;
    res_d  = res_q;
    ovo_d  = ovo_q;
    done_d = 1'b0;
    unique case (st_q)
      ACC_IDLE: if (start) st_d = ACC_ARMED;
      ACC_ARMED: if (tick) begin
        st_d  = ACC_RUN;
        idx_d = '0;
        sum_d = '0;
        ovr_d = 1'b0;
      end
      ACC_RUN: if (tick) begin
        if (idx_q == IW'(PERIODS - 1)) begin
          res_d  = sum_next;
          ovo_d  = ovr_next;
          done_d = 1'b1;
          st_d   = ACC_IDLE;
        end else begin
          sum_d = sum_next;
          ovr_d = ovr_next;
          idx_d = idx_q + IW'(1);
        end
      end
      default: st_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ACC_IDLE;
      idx_q  <= '0;
      sum_q  <= '0;
      ovr_q  <= 1'b0;
      res_q  <= '0;
      ovo_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sum_q  <= sum_d;
      ovr_q  <= ovr_d;
      res_q  <= res_d;
      ovo_q  <= ovo_d;
      done_q <= done_d;
    end
  end

  assign total     = res_q;
  assign done      = done_q;
  assign overrange = ovo_q;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  done_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(tick));

  // R9
  total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(res_q) && $stable(ovo_q)));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ACC_RUN && start && !tick) |=> (st_q == ACC_RUN));
endmodule

// File: rtl/pwm_ontime_accum.sv
module pwm_ontime_accum #(
  parameter int CLK_PER_PERIOD = 53333,
  parameter int FRAC_NUM       = 1,
  parameter int FRAC_DEN       = 3,
  parameter int PERIODS        = 60,
  parameter int MIN_COUNT      = 8000,
  parameter int MAX_COUNT      = 44800,
  parameter int TOTAL_W        = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               comp_in,
  input  logic               start,
  output logic               force_phase,
  output logic [TOTAL_W-1:0] total,
  output logic               done,
  output logic               overrange
);
  localparam int CW = $clog2(CLK_PER_PERIOD + 2);

  logic          rst_s_n;
  logic          tick;
  logic [CW-1:0] period_val;
  logic          period_subst;

  ota_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  ota_period_gen #(
    .CLK_PER_PERIOD (CLK_PER_PERIOD),
    .FRAC_NUM       (FRAC_NUM),
    .FRAC_DEN       (FRAC_DEN)
  ) u_per (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .tick        (tick),
    .force_phase (force_phase)
  );

  ota_ontime_meas #(
    .CLK_PER_PERIOD (CLK_PER_PERIOD),
    .MIN_COUNT      (MIN_COUNT),
    .MAX_COUNT      (MAX_COUNT),
    .SYNC_STAGES    (2),
    .CW             (CW)
  ) u_meas (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .comp_async   (comp_in),
    .tick         (tick),
    .period_val   (period_val),
    .period_subst (period_subst)
  );

  ota_cycle_accum #(
    .PERIODS (PERIODS),
    .CW      (CW),
    .TW      (TOTAL_W)
  ) u_acc (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .start        (start),
    .tick         (tick),
    .period_val   (period_val),
    .period_subst (period_subst),
    .total        (total),
    .done         (done),
    .overrange    (overrange)
  );
endmodule

// File: tb/sim_pwm_ontime_accum.sv
module sim_pwm_ontime_accum;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 40;
  localparam int FNUM = 1;
  localparam int FDEN = 3;
  localparam int NPER = 4;
  localparam int MINC = 5;
  localparam int MAXC = 35;
  localparam int TW   = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          comp_in = 1'b0;
  logic          start = 1'b0;
  logic          force_phase, done, overrange;
  logic [TW-1:0] total;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  pwm_ontime_accum #(
    .CLK_PER_PERIOD (BASE), .FRAC_NUM (FNUM), .FRAC_DEN (FDEN),
    .PERIODS (NPER), .MIN_COUNT (MINC), .MAX_COUNT (MAXC), .TOTAL_W (TW)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .comp_in (comp_in), .start (start),
    .force_phase (force_phase), .total (total), .done (done), .overrange (overrange)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_r1, m_r2, m_p, m_long, m_facc, m_s1, m_s2, m_s3, m_cnt, m_seen;
  int m_state, m_idx, m_sum, m_ovr, m_res, m_ovo, m_done;

  task automatic model_clear();
    m_p = 0; m_long = 0; m_facc = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    m_cnt = 0; m_seen = 0; m_state = 0; m_idx = 0; m_sum = 0; m_ovr = 0;
    m_res = 0; m_ovo = 0; m_done = 0;
  endtask

  initial begin
    m_r1 = 0; m_r2 = 0;
    model_clear();
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      model_clear();
    end else if (m_r2 == 0) begin
      m_r2 = m_r1; m_r1 = 1;
      model_clear();
    end else begin
      int len, tk, lvl, edg, hit, v, sb;
      len = BASE + m_long;
      tk  = (m_p == len - 1);
      lvl = m_s2;
      edg = (m_s2 != m_s3);
      hit = m_seen | edg;
      v   = hit ? (m_cnt + lvl) : (lvl ? MAXC : MINC);
      sb  = !hit;
      m_done = 0;
      if (m_state == 0) begin
        if (start) m_state = 1;
      end else if (m_state == 1) begin
        if (tk) begin m_state = 2; m_idx = 0; m_sum = 0; m_ovr = 0; end
      end else if (tk) begin
        if (m_idx == NPER - 1) begin
          m_res = m_sum + v; m_ovo = m_ovr | sb; m_done = 1; m_state = 0;
        end else begin
          m_sum = m_sum + v; m_ovr = m_ovr | sb; m_idx = m_idx + 1;
        end
      end
      if (tk) begin m_cnt = 0; m_seen = 0; end
      else begin m_cnt = m_cnt + lvl; m_seen = hit; end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = comp_in;
      if (tk) begin
        m_p = 0; m_facc = m_facc + FNUM;
        if (m_facc >= FDEN) begin m_facc = m_facc - FDEN; m_long = 1; end
        else m_long = 0;
      end else m_p = m_p + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    check(force_phase == (m_p < BASE/2), "R2 force_phase", force_phase, (m_p < BASE/2));
    check(total == TW'(m_res), "R6 total", total, m_res);
    check(done == m_done[0], "R6 done", done, m_done);
    check(overrange == m_ovo[0], "R7 overrange", overrange, m_ovo);
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // comparator stimulus
  int mode = 0, hi = 20, ph = 0;
  always @(negedge clk) begin
    ph++;
    case (mode)
      0: comp_in <= ((ph % 43) < hi);
      1: comp_in <= 1'b1;
      2: comp_in <= 1'b0;
      default: comp_in <= ((ph / 3) % 2 == 1);
    endcase
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (done !== 1'b1 && waited < 2000) begin
      @(negedge clk); waited++;
    end
  endtask

  initial begin
    int w;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(total == '0, "R1 total in reset", total, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(overrange == 1'b0, "R1 overrange in reset", overrange, 0);
    check(force_phase == 1'b1, "R1 force_phase in reset", force_phase, 1);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check(total == '0 && !overrange, "R1 outputs idle before start", total, 0);

    // R3 R5 R6 mid-scale duty, latency of start to done
    mode = 0; hi = 20;
    pulse_start();
    wait_done(w);
    check(w >= NPER*BASE - 2 && w <= (NPER+1)*(BASE+1) + 2, "R5 start-to-done latency", w, NPER*BASE);
    @(negedge clk);
    check(done == 1'b0, "R6 done lasts one clock", done, 0);
    check(overrange == 1'b0, "R7 no substitution for toggling comparator", overrange, 0);

    // R8 start during a running cycle is ignored
    hi = 8;
    pulse_start();
    repeat (BASE + 5) @(negedge clk);
    pulse_start();
    wait_done(w);
    @(negedge clk);
    w = 0;
    repeat (2*(NPER+1)*(BASE+1)) begin @(negedge clk); if (done) w++; end
    check(w == 0, "R8 busy start queued no extra cycle", w, 0);

    // R4 R7 comparator stuck high -> maximum counts
    mode = 1;
    repeat (3*BASE) @(negedge clk);
    pulse_start();
    wait_done(w);
    check(total == TW'(NPER*MAXC), "R4 stuck-high total", total, NPER*MAXC);
    check(overrange == 1'b1, "R7 stuck-high overrange", overrange, 1);

    // R9 result holds
    repeat (BASE) @(negedge clk);
    check(total == TW'(NPER*MAXC), "R9 total held", total, NPER*MAXC);

    // R4 stuck low -> minimum counts
    mode = 2;
    repeat (3*BASE) @(negedge clk);
    pulse_start();
    wait_done(w);
    check(total == TW'(NPER*MINC), "R4 stuck-low total", total, NPER*MINC);
    check(overrange == 1'b1, "R7 stuck-low overrange", overrange, 1);

    // fast toggling, overrange clears again
    mode = 3;
    pulse_start();
    wait_done(w);
    check(overrange == 1'b0, "R7 overrange cleared by clean cycle", overrange, 0);

    // back-to-back starts at several offsets
    mode = 0; hi = 30;
    for (int k = 0; k < 5; k++) begin
      repeat (k * 7) @(negedge clk);
      pulse_start();
      wait_done(w);
      check(done == 1'b1, "R6 cycle completes", done, 1);
    end
    repeat (20) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule